// File: doc/BRIEF.md
# ADC Control and Conversion Sequencer

This block is the digital front end that sits between a microcontroller bus and an 8-bit analog-to-digital converter. Software writes one control byte that carries a channel number, a conversion mode and a clock-divider code. Any accepted write with a nonzero divider code starts a conversion and sets a busy flag. The block then runs the converter through a fixed sequence: power-up, a sample window two converter clocks wide, select, conversion and completion.

The converter clock is derived from the system clock by a divider. The divider code table is not monotonic, and its zero code stops the converter clock altogether. The block produces this clock as a single-cycle enable pulse. Each pulse marks the active (falling) converter clock edge.

In single mode, the completion strobe powers the converter down and clears busy. In continuous mode, the converter is deselected for one converter clock and then sampled again. Busy stays set until software clears it. While busy is set, the control fields are write-protected. A write that clears busy can load new fields and restart in the same bus cycle. The result register follows the converter's data output except while the converter's load strobe is high.

Top module: `adc_sequencer`

## Requirements
- R1: After reset, ctrlReg is 0x00, busy is 0, and adcPower, adcSample, adcSelect and adcClkEn are all 0.
- R2: An accepted write loads wrData into ctrlReg. The fields are laid out as channel in bits 7:5, mode in bits 4:3 and divider code in bits 2:0. If the divider code is nonzero, the write also sets busy and raises adcPower on the next clock.
- R3: The divider code maps to a divisor as follows: 001→1, 010→2, 011→4, 100→6, 101→12, 110→8, 111→16. adcSample first rises exactly divisor system clocks after the clock edge that accepted the write. The edge that accepts the write does not count as a converter edge.
- R4: adcSample stays high for exactly 2×divisor system clocks. adcSelect rises divisor clocks after adcSample rises, at the middle of the sample window. adcSelect is low whenever adcSample rises.
- R5: Mode bit 4 set means differential, and it drives adcDiff high. muxPos always equals the channel field. muxNeg equals the channel with bit 0 inverted in differential mode, and 0 in single-ended mode.
- R6: When mode bit 3 is 0 (single conversion), a completion strobe removes adcPower and clears busy on the next clock.
- R7: When mode bit 3 is 1 (continuous), a completion strobe drops adcSelect. adcSample then rises again after exactly divisor system clocks, and busy stays set.
- R8: While busy is set, a write with wrBusyBit = 1 changes neither ctrlReg nor busy, and the running conversion continues.
- R9: A write with wrBusyBit = 0 is accepted even while busy is set. It loads new fields and restarts the sequence with the new divisor.
- R10: An accepted write with divider code 000 loads ctrlReg, clears busy and removes adcPower. After that write, no adcClkEn pulse and no adcSample occurs.
- R11: On every clock where adcLoad is low, result takes adcData. While adcLoad is high, result holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Control register write strobe |
| wrBusyBit | input | 1 | Busy bit value carried by the write; 0 clears busy |
| wrData | input | 8 | Control byte: channel[7:5], mode[4:3], divider code[2:0] |
| ctrlReg | output | 8 | Current control register contents |
| busy | output | 1 | Conversion in progress flag |
| result | output | DATA_W | Conversion result register |
| adcClkEn | output | 1 | One-cycle pulse per converter clock (active edge) |
| adcPower | output | 1 | Converter power enable |
| adcSample | output | 1 | Sample-and-hold window |
| adcSelect | output | 1 | Converter select |
| adcDiff | output | 1 | Differential input mode |
| muxPos | output | 3 | Positive input channel |
| muxNeg | output | 3 | Negative input channel (differential mode) |
| adcDone | input | 1 | Conversion complete strobe from converter |
| adcData | input | DATA_W | Converter output data |
| adcLoad | input | 1 | Converter result-writing strobe |

## Verification
The bench builds the block with DATA_W at its default of 8. The largest divisor is 16, so even the slowest conversion takes only a few hundred clocks. This lets one table walk all seven divider codes and check the start delay, sample width and select point of each.

A converter stub counts twelve converter clocks while select is high and then raises completion. This brings both the single and the continuous completion paths within reach. Directed cases cover the write-protect, clear-and-restart, divider-zero shutdown and result-hold behaviour.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CTRL_W = 8;
  localparam int MAX_DIV = 16;
  localparam int DIV_W = $clog2(MAX_DIV + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_SAMP0, ST_SAMP1, ST_CONV, ST_GAP
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCtrl;
    logic restartDiv;
    logic runDiv;
  } seqStrobe_t;

  function automatic logic [DIV_W-1:0] divOf(input logic [2:0] code);
    case (code)
      3'd1: return DIV_W'(1);
      3'd2: return DIV_W'(2);
      3'd3: return DIV_W'(4);
      3'd4: return DIV_W'(6);
      3'd5: return DIV_W'(12);
      3'd6: return DIV_W'(8);
      3'd7: return DIV_W'(16);
      default: return DIV_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [CTRL_W-1:0] wrData,
  input  logic [DATA_W-1:0] adcData,
  input  logic              adcLoad,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic              divTick,
  output logic [DATA_W-1:0] result,
  output logic              diffMode,
  output logic [2:0]        muxPos,
  output logic [2:0]        muxNeg
);
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      divReg  <= '0;
    end else if (strobe.loadCtrl) begin
      ctrlReg <= wrData;
      divReg  <= divOf(wrData[2:0]);
    end
  end

  assign divTick = strobe.runDiv && (divCnt == divReg - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  divCnt <= '0;
    else if (strobe.restartDiv) divCnt <= '0;
    else if (strobe.runDiv)     divCnt <= divTick ? '0 : divCnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         result <= '0;
    else if (!adcLoad) result <= adcData;
  end

  assign diffMode = ctrlReg[4];
  assign muxPos   = ctrlReg[7:5];
  assign muxNeg   = diffMode ? {ctrlReg[7:6], ~ctrlReg[5]} : 3'd0;
endmodule

// File: rtl/adc_seq_control.sv
module adc_seq_control
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrBusyBit,
  input  logic [2:0] wrPresc,
  input  logic       contMode,
  input  logic       divTick,
  input  logic       adcDone,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       adcPower,
  output logic       adcSample,
  output logic       adcSelect
);
  seqState_t state, stateNext;
  logic busyNext;
  logic accept, startOk, convEnd;

  assign accept  = wrEn && (!busy || !wrBusyBit);
  assign startOk = accept && (wrPresc != 3'd0);
  assign convEnd = (state == ST_CONV) && adcDone;

  assign strobe.loadCtrl   = accept;
  assign strobe.restartDiv = startOk || (convEnd && contMode);
  assign strobe.runDiv     = (state != ST_IDLE);

  always_comb begin
    stateNext = state;
    busyNext  = busy;
    case (state)
      ST_WAIT:  if (divTick) stateNext = ST_SAMP0;
      ST_SAMP0: if (divTick) stateNext = ST_SAMP1;
      ST_SAMP1: if (divTick) stateNext = ST_CONV;
      ST_CONV:
        if (adcDone) begin
          if (contMode) stateNext = ST_GAP;
          else begin
            stateNext = ST_IDLE;
            busyNext  = 1'b0;
          end
        end
      ST_GAP:   if (divTick) stateNext = ST_SAMP0;
      default:  ;
    endcase
    if (accept) begin
      stateNext = startOk ? ST_WAIT : ST_IDLE;
      busyNext  = startOk;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
    end else begin
      state <= stateNext;
      busy  <= busyNext;
    end
  end

  assign adcPower  = (state != ST_IDLE);
  assign adcSample = (state == ST_SAMP0) || (state == ST_SAMP1);
  assign adcSelect = (state == ST_SAMP1) || (state == ST_CONV);
endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrBusyBit,
  input  logic [7:0]        wrData,
  output logic [7:0]        ctrlReg,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              adcClkEn,
  output logic              adcPower,
  output logic              adcSample,
  output logic              adcSelect,
  output logic              adcDiff,
  output logic [2:0]        muxPos,
  output logic [2:0]        muxNeg,
  input  logic              adcDone,
  input  logic [DATA_W-1:0] adcData,
  input  logic              adcLoad
);
  seqStrobe_t strobe;
  logic divTick;

  adc_seq_control u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBusyBit(wrBusyBit),
    .wrPresc(wrData[2:0]), .contMode(ctrlReg[3]), .divTick(divTick),
    .adcDone(adcDone), .strobe(strobe), .busy(busy), .adcPower(adcPower),
    .adcSample(adcSample), .adcSelect(adcSelect)
  );

  adc_seq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .adcData(adcData), .adcLoad(adcLoad), .ctrlReg(ctrlReg),
    .divTick(divTick), .result(result), .diffMode(adcDiff),
    .muxPos(muxPos), .muxNeg(muxNeg)
  );

  assign adcClkEn = divTick;
endmodule

// File: rtl/adc_sequencer_chk.sv
module adc_sequencer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrBusyBit,
  input logic [7:0]        ctrlReg,
  input logic              busy,
  input logic [DATA_W-1:0] result,
  input logic              adcClkEn,
  input logic              adcPower,
  input logic              adcSample,
  input logic              adcSelect,
  input logic              adcLoad
);
  a_r4_select_low_at_sample_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcSample) |-> !adcSelect);

  a_r2_sample_needs_power: assert property (@(posedge clk) disable iff (!rstN)
    (adcSample || adcSelect) |-> adcPower);

  a_r10_no_clock_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !adcPower |-> !adcClkEn);

  a_r8_protect_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && wrBusyBit) |=> ($stable(ctrlReg) && busy));

  a_r11_hold_on_load: assert property (@(posedge clk) disable iff (!rstN)
    adcLoad |=> $stable(result));
endmodule

bind adc_sequencer adc_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBusyBit(wrBusyBit),
  .ctrlReg(ctrlReg), .busy(busy), .result(result), .adcClkEn(adcClkEn),
  .adcPower(adcPower), .adcSample(adcSample), .adcSelect(adcSelect),
  .adcLoad(adcLoad)
);

// File: tb/tb_adc_sequencer.sv
module tb_adc_sequencer;
  localparam int DATA_W = 8;
  localparam int NV = 7;
  localparam logic [7:0] VCTRL [NV] = '{8'h01, 8'h72, 8'hC3, 8'hB4, 8'h55, 8'hE6, 8'h97};
  localparam int VDIV [NV] = '{1, 2, 4, 6, 12, 8, 16};

  logic clk = 0, rstN = 0, wrEn = 0, wrBusyBit = 0, adcDone = 0, adcLoad = 0;
  logic [7:0] wrData = '0;
  logic [DATA_W-1:0] adcData = '0;
  logic [7:0] ctrlReg;
  logic [DATA_W-1:0] result;
  logic busy, adcClkEn, adcPower, adcSample, adcSelect, adcDiff;
  logic [2:0] muxPos, muxNeg;
  int checks = 0, errors = 0, cycles = 0;
  int stubCnt = 0;

  always #5 clk = ~clk;

  adc_sequencer #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBusyBit(wrBusyBit), .wrData(wrData),
    .ctrlReg(ctrlReg), .busy(busy), .result(result), .adcClkEn(adcClkEn),
    .adcPower(adcPower), .adcSample(adcSample), .adcSelect(adcSelect),
    .adcDiff(adcDiff), .muxPos(muxPos), .muxNeg(muxNeg), .adcDone(adcDone),
    .adcData(adcData), .adcLoad(adcLoad)
  );

  // converter stub: completion after 12 converter clocks of select
  always @(posedge clk) begin
    if (!adcSelect) begin
      stubCnt <= 0;
      adcDone <= 1'b0;
    end else if (adcClkEn) begin
      stubCnt <= stubCnt + 1;
      adcDone <= (stubCnt == 11);
    end else adcDone <= 1'b0;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] d, input logic keepBit);
    wrData = d; wrBusyBit = keepBit; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitSample(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!adcSample && n < 200);
  endtask

  task automatic waitNotBusy();
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
  endtask

  initial begin
    int n, w, selAt, dv, g;
    logic [7:0] c;
    repeat (3) @(negedge clk);
    check(ctrlReg == 8'h00 && !busy, "R1 reg/busy", int'(ctrlReg), 0);
    check(!adcPower && !adcSample && !adcSelect && !adcClkEn, "R1 outputs", int'(adcPower), 0);
    rstN = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      c = VCTRL[i]; dv = VDIV[i];
      doWrite(c, 1'b1);
      check(ctrlReg == c, "R2 load", int'(ctrlReg), int'(c));
      check(busy && adcPower, "R2 busy/power", int'(busy), 1);
      waitSample(n);
      check(n == dv, "R3 start delay", n, dv);
      check(muxPos == c[7:5], "R5 muxPos", int'(muxPos), int'(c[7:5]));
      check(adcDiff == c[4], "R5 diff", int'(adcDiff), int'(c[4]));
      check(muxNeg == (c[4] ? {c[7:6], ~c[5]} : 3'd0), "R5 muxNeg", int'(muxNeg),
            int'(c[4] ? {c[7:6], ~c[5]} : 3'd0));
      w = 0; selAt = -1;
      while (adcSample && w < 200) begin
        if (selAt < 0 && adcSelect) selAt = w;
        w++;
        @(negedge clk);
      end
      check(w == 2 * dv, "R4 sample width", w, 2 * dv);
      check(selAt == dv, "R4 select midpoint", selAt, dv);
      waitNotBusy();
      @(negedge clk);
      check(!busy && !adcPower, "R6 single done", int'(adcPower), 0);
    end

    // continuous mode, divisor 2
    doWrite(8'h4A, 1'b1);
    for (int k = 0; k < 2000 && !adcSelect; k++) @(negedge clk);
    for (int k = 0; k < 2000 && adcSelect; k++) @(negedge clk);
    g = 0;
    while (!adcSample && g < 200) begin g++; @(negedge clk); end
    check(g == 2, "R7 gap length", g, 2);
    check(busy == 1'b1, "R7 busy held", int'(busy), 1);

    // write-protect while busy
    doWrite(8'hFF, 1'b1);
    check(ctrlReg == 8'h4A, "R8 protected reg", int'(ctrlReg), 8'h4A);
    check(busy && adcPower, "R8 still running", int'(busy), 1);

    // clear and restart in one write
    doWrite(8'hB1, 1'b0);
    check(ctrlReg == 8'hB1 && busy, "R9 reload", int'(ctrlReg), 8'hB1);
    waitSample(n);
    check(n == 1, "R9 new divisor", n, 1);
    check(muxNeg == 3'd4, "R9 new pair", int'(muxNeg), 4);
    waitNotBusy();
    @(negedge clk);

    // divider code zero while idle
    doWrite(8'h60, 1'b1);
    check(ctrlReg == 8'h60 && !busy && !adcPower, "R10 idle stop", int'(busy), 0);
    g = 0;
    for (int k = 0; k < 40; k++) begin
      if (adcClkEn || adcSample) g++;
      @(negedge clk);
    end
    check(g == 0, "R10 no clock", g, 0);

    // divider code zero stopping a continuous run
    doWrite(8'h0B, 1'b1);
    repeat (5) @(negedge clk);
    doWrite(8'h08, 1'b0);
    check(!busy && !adcPower, "R10 stop running", int'(adcPower), 0);

    // result hold
    adcData = 8'h5A; adcLoad = 1'b0;
    @(negedge clk);
    check(result == 8'h5A, "R11 track", int'(result), 8'h5A);
    adcLoad = 1'b1; adcData = 8'hC3;
    repeat (2) @(negedge clk);
    check(result == 8'h5A, "R11 hold", int'(result), 8'h5A);
    adcLoad = 1'b0;
    @(negedge clk);
    check(result == 8'hC3, "R11 release", int'(result), 8'hC3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule